// File: doc/BRIEF.md
# Keyed configuration data port

This block gives firmware a small, keyed table of configuration items behind two bus registers. Firmware writes a 16-bit key into a selector register, then streams the chosen item one byte at a time through a data register. Each byte access moves an internal cursor forward. Reads past the end of the item return zero. Items whose key carries a write-permission bit can also be filled by the firmware. When the last byte of such an item is written, the block pulses a completion strobe that carries the key, and the cursor rewinds to the start.

The table has two banks of equal size: a generic bank and a platform-local bank. A side load port fills the table. It can set an item length, write a single byte, or store a 16-, 32- or 64-bit value as an item in little-endian byte order.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset, key 0 is selected with the cursor at 0, `bus_rdata_o` is 0 and `done_o` is low. Data reads made before any select stream entry 0 of the generic bank.
- R2: A 16-bit write to the selector always sets the cursor to 0. Key bit 15 picks the bank (0 generic, 1 platform-local). Key bits 13:0 give the entry number within that bank.
- R3: A key whose bits 13:0 are at or above `N_ENT` is replaced by the invalid key 16'hFFFF. While it is selected, reads return 0 and writes change nothing.
- R4: A data read with a valid selection, a loaded entry and cursor < length returns the byte at the cursor on `bus_rdata_o` one cycle after the request, and advances the cursor by one.
- R5: A data read of an entry that was never loaded, or with cursor equal to the length, returns 0 and leaves the cursor unchanged.
- R6: A data write stores `bus_wdata_i[7:0]` at the cursor and advances the cursor only when key bit 14 is set and cursor < length. Otherwise the write is dropped.
- R7: A data write that brings the cursor up to the length raises `done_o` for exactly one cycle in the next cycle, with `done_key_o` equal to the selected key, and returns the cursor to 0.
- R8: Only these accesses have an effect: a write with `bus_size_i`=1 to address 0 (selector), and a byte access (`bus_size_i`=0) to address 2 or 3 (data). Every other access is ignored, and a read of any kind other than a data read returns 0.
- R9: A word load with `ld_size_i` 0, 1 or 2 stores 2, 4 or 8 bytes of `ld_word_i`, least significant byte at offset 0, and sets the length to that byte count. Size code 3 is ignored.
- R10: A length load is refused when `ld_cb_i` is set and key bit 14 is clear, or when the length exceeds `DEPTH`. A refused load leaves the entry unloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access request |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 2 | Byte address: 0-1 selector, 2-3 data |
| bus_size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| done_o | output | 1 | Completion strobe of a write-back item |
| done_key_o | output | 16 | Key of the completed item |
| ld_len_valid_i | input | 1 | Load an entry length |
| ld_byte_valid_i | input | 1 | Load one entry byte |
| ld_word_valid_i | input | 1 | Load a little-endian value as an entry |
| ld_key_i | input | 16 | Key of the entry being loaded |
| ld_cb_i | input | 1 | Length load registers a write-back item |
| ld_len_i | input | 16 | Length for a length load |
| ld_pos_i | input | 16 | Byte position for a byte load |
| ld_byte_i | input | 8 | Byte for a byte load |
| ld_word_i | input | 64 | Value for a word load |
| ld_size_i | input | 2 | Word load size: 0 16-bit, 1 32-bit, 2 64-bit |

## Verification
The bench goes after the edges of the cursor:
- Reads that run one byte past the end must give zero and must not wrap.
- A select issued mid-item must restart at byte 0, and a design that kept the old cursor would replay from the wrong place.
- A one-byte write-back item written twice in a row must strobe completion twice.
- An item written to its end must read back from offset 0, which catches a missing rewind.

It also tries out-of-range keys, a write made through a key without the write bit that targets an entry that is writable, refused registrations, wrong-size and wrong-register accesses, and multi-byte loads. A design that byte-swapped, ignored the access size or leaked a write through a stale selection would corrupt the values read back.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
  localparam int unsigned KEY_W      = 16;
  localparam logic [15:0] KEY_INVALID = 16'hFFFF;
  localparam int unsigned BANK_BIT   = 15;
  localparam int unsigned WRCH_BIT   = 14;

  typedef enum logic [1:0] {ACC_NONE, ACC_SEL, ACC_RD, ACC_WR} acc_e;

  // flat entry number: generic bank first, then platform-local bank
  function automatic int unsigned ent_index(logic [15:0] key, int unsigned n_ent);
    return (key[BANK_BIT] ? n_ent : 0) + 32'(key[13:0]);
  endfunction

  function automatic logic idx_ok(logic [15:0] key, int unsigned n_ent);
    return 32'(key[13:0]) < n_ent;
  endfunction
endpackage

// File: rtl/kcfg_decode.sv
module kcfg_decode
  import keyed_cfg_pkg::*;
(
  input  logic       valid_i,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [1:0] size_i,
  output acc_e       acc_o
);
  logic sel_hit, dat_hit;

  assign sel_hit = valid_i && we_i && (addr_i == 2'd0) && (size_i == 2'd1);
  assign dat_hit = valid_i && addr_i[1] && (size_i == 2'd0);

  always_comb begin
    acc_o = ACC_NONE;
    if (sel_hit)      acc_o = ACC_SEL;
    else if (dat_hit) acc_o = we_i ? ACC_WR : ACC_RD;
  end
endmodule

// File: rtl/kcfg_store.sv
module kcfg_store
  import keyed_cfg_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned ENT_W = $clog2(2 * N_ENT),
  localparam int unsigned OFF_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ENT_W-1:0] rd_ent_i,
  input  logic [OFF_W-1:0] rd_off_i,
  output logic [7:0]       rd_byte_o,
  output logic [LEN_W-1:0] rd_len_o,
  output logic             rd_has_o,
  input  logic             wr_en_i,
  input  logic [ENT_W-1:0] wr_ent_i,
  input  logic [OFF_W-1:0] wr_off_i,
  input  logic [7:0]       wr_byte_i,
  input  logic             ld_len_valid_i,
  input  logic             ld_byte_valid_i,
  input  logic             ld_word_valid_i,
  input  logic [15:0]      ld_key_i,
  input  logic             ld_cb_i,
  input  logic [15:0]      ld_len_i,
  input  logic [15:0]      ld_pos_i,
  input  logic [7:0]       ld_byte_i,
  input  logic [63:0]      ld_word_i,
  input  logic [1:0]       ld_size_i
);
  localparam int unsigned N_TOT = 2 * N_ENT;

  logic [7:0]       mem_q [N_TOT][DEPTH];
  logic [LEN_W-1:0] len_q [N_TOT];
  logic [N_TOT-1:0] has_q;

  logic [ENT_W-1:0] ld_ent;
  logic             key_ok, len_ok, byte_ok, word_ok;
  int unsigned      wbytes;

  assign ld_ent  = ENT_W'(ent_index(ld_key_i, N_ENT));
  assign key_ok  = idx_ok(ld_key_i, N_ENT);
  assign len_ok  = ld_len_valid_i && key_ok && (!ld_cb_i || ld_key_i[WRCH_BIT]) &&
                   (32'(ld_len_i) <= DEPTH);
  assign byte_ok = ld_byte_valid_i && key_ok && (32'(ld_pos_i) < DEPTH);
  assign word_ok = ld_word_valid_i && key_ok && (ld_size_i != 2'd3);

  always_comb begin
    case (ld_size_i)
      2'd0:    wbytes = 2;
      2'd1:    wbytes = 4;
      default: wbytes = 8;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (byte_ok) mem_q[ld_ent][ld_pos_i[OFF_W-1:0]] <= ld_byte_i;
    for (int b = 0; b < 8; b++) begin
      if (word_ok && (b < wbytes) && (b < DEPTH))
        mem_q[ld_ent][OFF_W'(b)] <= ld_word_i[8*b +: 8];
    end
    if (wr_en_i) mem_q[wr_ent_i][wr_off_i] <= wr_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_TOT; e++) len_q[e] <= '0;
      has_q <= '0;
    end else if (len_ok) begin
      len_q[ld_ent] <= LEN_W'(ld_len_i);
      has_q[ld_ent] <= 1'b1;
    end else if (word_ok) begin
      len_q[ld_ent] <= LEN_W'(wbytes);
      has_q[ld_ent] <= 1'b1;
    end
  end

  assign rd_byte_o = mem_q[rd_ent_i][rd_off_i];
  assign rd_len_o  = len_q[rd_ent_i];
  assign rd_has_o  = has_q[rd_ent_i];
endmodule

// File: rtl/kcfg_cursor.sv
module kcfg_cursor
  import keyed_cfg_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned ENT_W = $clog2(2 * N_ENT),
  localparam int unsigned OFF_W = $clog2(DEPTH),
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_e             acc_i,
  input  logic [15:0]      wdata_i,
  input  logic [7:0]       byte_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             has_i,
  output logic [ENT_W-1:0] ent_o,
  output logic [OFF_W-1:0] off_lo_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_byte_o,
  output logic [7:0]       rdata_o,
  output logic             done_o,
  output logic [15:0]      done_key_o,
  output logic [15:0]      key_o,
  output logic [LEN_W-1:0] off_o
);
  logic [15:0]      key_q;
  logic [LEN_W-1:0] off_q, off_inc;
  logic             sel_valid, in_range, rd_hit, wr_hit, wr_last;

  assign sel_valid = (key_q != KEY_INVALID);
  assign in_range  = (off_q < len_i);
  assign off_inc   = off_q + LEN_W'(1);
  assign rd_hit    = (acc_i == ACC_RD) && sel_valid && has_i && in_range;
  assign wr_hit    = (acc_i == ACC_WR) && sel_valid && key_q[WRCH_BIT] && in_range;
  assign wr_last   = wr_hit && (off_inc == len_i);

  assign ent_o     = sel_valid ? ENT_W'(ent_index(key_q, N_ENT)) : '0;
  assign off_lo_o  = off_q[OFF_W-1:0];
  assign wr_en_o   = wr_hit;
  assign wr_byte_o = wdata_i[7:0];
  assign key_o     = key_q;
  assign off_o     = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q      <= '0;
      off_q      <= '0;
      rdata_o    <= '0;
      done_o     <= 1'b0;
      done_key_o <= '0;
    end else begin
      rdata_o    <= rd_hit ? byte_i : 8'h00;
      done_o     <= wr_last;
      done_key_o <= wr_last ? key_q : 16'h0000;
      if (acc_i == ACC_SEL) begin
        off_q <= '0;
        key_q <= idx_ok(wdata_i, N_ENT) ? wdata_i : KEY_INVALID;
      end else if (rd_hit) begin
        off_q <= off_inc;
      end else if (wr_hit) begin
        off_q <= wr_last ? '0 : off_inc;
      end
    end
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import keyed_cfg_pkg::*;
#(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_valid_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [1:0]  bus_size_i,
  input  logic [15:0] bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        done_o,
  output logic [15:0] done_key_o,
  input  logic        ld_len_valid_i,
  input  logic        ld_byte_valid_i,
  input  logic        ld_word_valid_i,
  input  logic [15:0] ld_key_i,
  input  logic        ld_cb_i,
  input  logic [15:0] ld_len_i,
  input  logic [15:0] ld_pos_i,
  input  logic [7:0]  ld_byte_i,
  input  logic [63:0] ld_word_i,
  input  logic [1:0]  ld_size_i
);
  localparam int unsigned ENT_W = $clog2(2 * N_ENT);
  localparam int unsigned OFF_W = $clog2(DEPTH);
  localparam int unsigned LEN_W = $clog2(DEPTH + 1);

  acc_e             acc;
  logic [ENT_W-1:0] ent;
  logic [OFF_W-1:0] off_lo;
  logic [7:0]       st_byte, wr_byte;
  logic [LEN_W-1:0] st_len;
  logic             st_has, wr_en;
  logic [15:0]      cur_key;
  logic [LEN_W-1:0] cur_off;

  kcfg_decode u_decode (
    .valid_i (bus_valid_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .size_i  (bus_size_i),
    .acc_o   (acc)
  );

  kcfg_cursor #(.N_ENT(N_ENT), .DEPTH(DEPTH)) u_cursor (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .wdata_i    (bus_wdata_i),
    .byte_i     (st_byte),
    .len_i      (st_len),
    .has_i      (st_has),
    .ent_o      (ent),
    .off_lo_o   (off_lo),
    .wr_en_o    (wr_en),
    .wr_byte_o  (wr_byte),
    .rdata_o    (bus_rdata_o),
    .done_o     (done_o),
    .done_key_o (done_key_o),
    .key_o      (cur_key),
    .off_o      (cur_off)
  );

  kcfg_store #(.N_ENT(N_ENT), .DEPTH(DEPTH)) u_store (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .rd_ent_i        (ent),
    .rd_off_i        (off_lo),
    .rd_byte_o       (st_byte),
    .rd_len_o        (st_len),
    .rd_has_o        (st_has),
    .wr_en_i         (wr_en),
    .wr_ent_i        (ent),
    .wr_off_i        (off_lo),
    .wr_byte_i       (wr_byte),
    .ld_len_valid_i  (ld_len_valid_i),
    .ld_byte_valid_i (ld_byte_valid_i),
    .ld_word_valid_i (ld_word_valid_i),
    .ld_key_i        (ld_key_i),
    .ld_cb_i         (ld_cb_i),
    .ld_len_i        (ld_len_i),
    .ld_pos_i        (ld_pos_i),
    .ld_byte_i       (ld_byte_i),
    .ld_word_i       (ld_word_i),
    .ld_size_i       (ld_size_i)
  );
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
  parameter int unsigned N_ENT = 4,
  parameter int unsigned LEN_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_valid_i,
  input logic             bus_we_i,
  input logic [1:0]       bus_addr_i,
  input logic [1:0]       bus_size_i,
  input logic [7:0]       bus_rdata_o,
  input logic             done_o,
  input logic [15:0]      cur_key,
  input logic [LEN_W-1:0] cur_off
);
  logic is_rd, is_wr, is_sel;
  assign is_rd  = bus_valid_i && !bus_we_i && bus_addr_i[1] && (bus_size_i == 2'd0);
  assign is_wr  = bus_valid_i && bus_we_i && bus_addr_i[1] && (bus_size_i == 2'd0);
  assign is_sel = bus_valid_i && bus_we_i && (bus_addr_i == 2'd0) && (bus_size_i == 2'd1);

  p_rdata_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(is_rd) |-> (bus_rdata_o == 8'h00));

  p_done_after_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(is_wr));

  p_done_rewinds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cur_off == '0));

  p_select_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(is_sel) |-> (cur_off == '0));

  p_key_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_key == 16'hFFFF) || (32'(cur_key[13:0]) < N_ENT));

  p_invalid_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(is_rd && (cur_key == 16'hFFFF)) |-> (bus_rdata_o == 8'h00));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(.N_ENT(N_ENT), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_size_i  (bus_size_i),
  .bus_rdata_o (bus_rdata_o),
  .done_o      (done_o),
  .cur_key     (cur_key),
  .cur_off     (cur_off)
);

// File: tb/test_keyed_cfg_port.sv
`timescale 1ns/1ps
module test_keyed_cfg_port;
  localparam int N = 4;
  localparam int D = 8;
  localparam int INV = 16'hFFFF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_valid_i = 0, bus_we_i = 0;
  logic [1:0]  bus_addr_i = 0, bus_size_i = 0;
  logic [15:0] bus_wdata_i = 0;
  logic [7:0]  bus_rdata_o;
  logic        done_o;
  logic [15:0] done_key_o;
  logic        ld_len_valid_i = 0, ld_byte_valid_i = 0, ld_word_valid_i = 0, ld_cb_i = 0;
  logic [15:0] ld_key_i = 0, ld_len_i = 0, ld_pos_i = 0;
  logic [7:0]  ld_byte_i = 0;
  logic [63:0] ld_word_i = 0;
  logic [1:0]  ld_size_i = 0;

  always #5 clk_i = ~clk_i;

  keyed_cfg_port #(.N_ENT(N), .DEPTH(D)) i_keyed_cfg_port (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  int m_mem [2*N*D];
  int m_len [2*N];
  bit m_has [2*N];
  int m_key = 0, m_off = 0;
  int e_rd = 0, e_done = 0, e_dkey = 0;

  function automatic int ent_of(int k);
    return ((k & 16'h8000) != 0 ? N : 0) + (k & 16'h3FFF);
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int k, e, nb;
    e_rd = 0; e_done = 0; e_dkey = 0;
    k = int'(ld_key_i);
    if (ld_len_valid_i && (k & 16'h3FFF) < N && (!ld_cb_i || (k & 16'h4000) != 0) && ld_len_i <= D) begin
      e = ent_of(k); m_len[e] = ld_len_i; m_has[e] = 1;
    end
    if (ld_byte_valid_i && (k & 16'h3FFF) < N && ld_pos_i < D)
      m_mem[ent_of(k)*D + ld_pos_i] = ld_byte_i;
    if (ld_word_valid_i && (k & 16'h3FFF) < N && ld_size_i != 3) begin
      e = ent_of(k); nb = 2 << ld_size_i;
      for (int b = 0; b < nb; b++) m_mem[e*D + b] = int'(ld_word_i[8*b +: 8]);
      m_len[e] = nb; m_has[e] = 1;
    end
    if (bus_valid_i) begin
      if (!bus_we_i && bus_addr_i[1] && bus_size_i == 0) begin
        if (m_key != INV) begin
          e = ent_of(m_key);
          if (m_has[e] && m_off < m_len[e]) begin e_rd = m_mem[e*D + m_off]; m_off++; end
        end
      end else if (bus_we_i && bus_addr_i[1] && bus_size_i == 0) begin
        if (m_key != INV && (m_key & 16'h4000) != 0) begin
          e = ent_of(m_key);
          if (m_off < m_len[e]) begin
            m_mem[e*D + m_off] = bus_wdata_i[7:0];
            m_off++;
            if (m_off == m_len[e]) begin m_off = 0; e_done = 1; e_dkey = m_key; end
          end
        end
      end else if (bus_we_i && bus_addr_i == 0 && bus_size_i == 1) begin
        m_off = 0;
        m_key = ((bus_wdata_i & 16'h3FFF) < N) ? int'(bus_wdata_i) : INV;
      end
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(negedge clk_i);
    chk(tag, "rdata", 16'(bus_rdata_o), 16'(e_rd));
    chk(tag, "done", 16'(done_o), 16'(e_done));
    chk(tag, "done_key", done_key_o, 16'(e_dkey));
    bus_valid_i = 0; bus_we_i = 0; bus_addr_i = 0; bus_size_i = 0; bus_wdata_i = 0;
    ld_len_valid_i = 0; ld_byte_valid_i = 0; ld_word_valid_i = 0; ld_cb_i = 0;
  endtask

  task automatic bus(string tag, bit we, int addr, int size, int wd);
    bus_valid_i = 1; bus_we_i = we; bus_addr_i = 2'(addr); bus_size_i = 2'(size);
    bus_wdata_i = 16'(wd);
    cyc(tag);
  endtask

  task automatic sel(string tag, int key); bus(tag, 1, 0, 1, key); endtask
  task automatic rd(string tag); bus(tag, 0, 2, 0, 0); endtask
  task automatic wr(string tag, int v); bus(tag, 1, 3, 0, v); endtask

  task automatic ld_len(string tag, int key, int len, bit cb);
    ld_len_valid_i = 1; ld_key_i = 16'(key); ld_len_i = 16'(len); ld_cb_i = cb;
    cyc(tag);
  endtask
  task automatic ld_byte(string tag, int key, int pos, int v);
    ld_byte_valid_i = 1; ld_key_i = 16'(key); ld_pos_i = 16'(pos); ld_byte_i = 8'(v);
    cyc(tag);
  endtask
  task automatic ld_word(string tag, int key, int size, logic [63:0] v);
    ld_word_valid_i = 1; ld_key_i = 16'(key); ld_size_i = 2'(size); ld_word_i = v;
    cyc(tag);
  endtask

  initial begin
    for (int i = 0; i < 2*N*D; i++) m_mem[i] = 0;
    for (int i = 0; i < 2*N; i++) begin m_len[i] = 0; m_has[i] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    cyc("R1");
    // R1: entry 0 loaded, read without any select
    ld_len("R1", 16'h0000, 5, 0);
    for (int i = 0; i < 5; i++) ld_byte("R1", 16'h0000, i, 8'hA0 + i);
    rd("R1"); rd("R1");
    // R2: select rewinds mid-item; R4 stream; R5 end of item
    sel("R2", 16'h0000);
    for (int i = 0; i < 5; i++) rd("R4");
    rd("R5"); rd("R5");
    // R9: little-endian word loads, both banks
    ld_word("R9", 16'h0001, 1, 64'h0000_0000_4433_2211);
    ld_word("R9", 16'h8002, 0, 64'h0000_0000_0000_BEEF);
    ld_word("R9", 16'h8003, 2, 64'h0807_0605_0403_0201);
    ld_word("R9", 16'h8000, 3, 64'hFFFF_FFFF_FFFF_FFFF);
    sel("R9", 16'h0001); for (int i = 0; i < 5; i++) rd("R9");
    sel("R2", 16'h8002); for (int i = 0; i < 3; i++) rd("R2");
    sel("R9", 16'h8003); for (int i = 0; i < 9; i++) rd("R9");
    sel("R9", 16'h8000); rd("R9");
    // R5: never-loaded entry
    sel("R5", 16'h0002); rd("R5");
    // R10: refused registrations
    ld_len("R10", 16'h0002, 4, 1);
    sel("R10", 16'h0002); rd("R10");
    ld_len("R10", 16'h8001, 9, 0);
    sel("R10", 16'h8001); rd("R10");
    // R3: out-of-range keys
    sel("R3", 16'h0004); rd("R3"); wr("R3", 8'h99);
    sel("R3", 16'h3FFF); rd("R3");
    // R6/R7: write-back item of length 3
    ld_len("R10", 16'h4003, 3, 1);
    sel("R6", 16'h4003);
    wr("R6", 8'h5A); wr("R6", 8'h5B); wr("R7", 8'h5C);
    rd("R7"); rd("R7"); rd("R7");
    wr("R6", 8'h66); rd("R6");
    // R6: same entry, key without the write bit
    sel("R6", 16'h0003); wr("R6", 8'h77);
    sel("R6", 16'h0003); rd("R6");
    // R8: wrong register or size is ignored
    sel("R8", 16'h0000); rd("R8");
    bus("R8", 0, 0, 0, 0);
    bus("R8", 0, 2, 1, 0);
    bus("R8", 1, 0, 0, 16'h0001);
    bus("R8", 1, 1, 1, 16'h0001);
    bus("R8", 1, 2, 1, 16'h0001);
    rd("R8");
    // R7: one-byte item, back-to-back completions
    ld_len("R7", 16'h4002, 1, 0);
    sel("R7", 16'h4002);
    wr("R7", 8'h11); wr("R7", 8'h22); rd("R7");
    cyc("R7");
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule